// File: doc/BRIEF.md
# Multi-code decimal up/down counter

A synchronous decade counter whose single digit runs through 0 to 9 and wraps around at either end, counting up or down under a direction input. It does not show a plain binary count. The output word carries the digit in one of five decimal codes, picked by a select field: excess-3, 2421, 2-out-of-5, biquinary and the weighted code 6 4 2 -1.

Internally the digit is held once, as a 4-bit value. The select field is registered. The output word is the registered digit encoded under the registered select. So a change of code takes effect on the next clock edge and never disturbs the count. A terminal-count flag marks the step that is about to wrap. It lets a neighbouring digit know that a carry or borrow is due.

Top module: `dec_code_counter`

## Requirements
- R1: Select 0 gives excess-3: code_o[3:0] = digit + 3 and code_o[6:4] = 0. The select values 5, 6 and 7 are illegal and behave exactly like select 0.
- R2: Select 1 gives 2421. Digits 0 to 4 give code_o[3:0] = 0000 to 0100. Digits 5 to 9 give 1011, 1100, 1101, 1110 and 1111. code_o[6:4] = 0.
- R3: Select 2 gives 2-out-of-5 on code_o[4:0], with weights 7,4,2,1,0 from bit 4 down to bit 0. The words for digits 0 to 9 are 11000, 00011, 00101, 00110, 01001, 01010, 01100, 10001, 10010 and 10100. code_o[6:5] = 0.
- R4: Select 3 gives biquinary on all 7 bits. code_o[6:5] is 01 for digits 0 to 4 and 10 for digits 5 to 9. code_o[4:0] is one-hot, with bit (digit mod 5) set.
- R5: Select 4 gives 6 4 2 -1 on code_o[3:0], with bit 3 weighted 6, bit 2 weighted 4, bit 1 weighted 2 and bit 0 weighted -1. The words for digits 0 to 9 are 0000, 0011, 0010, 0101, 0100, 1001, 1000, 1011, 1010 and 1101. code_o[6:4] = 0.
- R6: With en_i=1 and dir_i=1, each rising clock edge adds one to the digit, and 9 wraps to 0.
- R7: With en_i=1 and dir_i=0, each rising clock edge subtracts one from the digit, and 0 wraps to 9.
- R8: With en_i=0, the digit holds its value across clock edges.
- R9: tc_o is 1 exactly when en_i=1 and either dir_i=1 with the digit at 9, or dir_i=0 with the digit at 0. It is combinational from the current inputs and state.
- R10: A change of code_sel_i leaves the digit unchanged. code_o shows the current digit in the new code after the next rising clock edge.
- R11: While rst_ni=0, the digit is 0 and the registered select is excess-3, so code_o = 0000011. The first clock edge after release loads the selected code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable |
| dir_i | input | 1 | 1 counts up, 0 counts down |
| code_sel_i | input | 3 | Output code select |
| code_o | output | 7 | Digit in the selected code, zero padded |
| tc_o | output | 1 | Terminal count: the next enabled step wraps |

## Verification
Every code is run through a full cycle of ten digits and more. Excess-3, 2421 and biquinary are run counting up, and 2-out-of-5 and 6 4 2 -1 counting down, so that every table entry and both wrap directions are seen. The terminal flag is compared on every step, which separates a wrong wrap point from a wrong encoding.

A run with the enable low shows that the digit holds. A change of select made while the count is held shows the next-edge re-encode on an unchanged digit. An illegal select value must reproduce excess-3 words. A reset in mid-run must return the output to the excess-3 word for zero.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int unsigned NUM_DIGITS = 10;
  localparam int unsigned DIG_W      = $clog2(NUM_DIGITS);
  localparam int unsigned CODE_W     = 7;
  localparam int unsigned SEL_W      = 3;
  localparam int unsigned NUM_CODES  = 5;

  typedef enum logic [SEL_W-1:0] {
    CODE_XS3   = 3'd0,
    CODE_2421  = 3'd1,
    CODE_2OF5  = 3'd2,
    CODE_BIQ   = 3'd3,
    CODE_W642N = 3'd4
  } code_e;

  function automatic logic [CODE_W-1:0] encode(input logic [DIG_W-1:0] d, input int unsigned c);
    logic [CODE_W-1:0] w;
    logic              hi;
    logic [DIG_W-1:0]  pos;
    hi  = (d >= DIG_W'(5));
    pos = hi ? d - DIG_W'(5) : d;
    w   = '0;
    case (c)
      1: w[3:0] = hi ? d + DIG_W'(6) : d;
      2: case (d)
           4'd0: w[4:0] = 5'b11000;
           4'd1: w[4:0] = 5'b00011;
           4'd2: w[4:0] = 5'b00101;
           4'd3: w[4:0] = 5'b00110;
           4'd4: w[4:0] = 5'b01001;
           4'd5: w[4:0] = 5'b01010;
           4'd6: w[4:0] = 5'b01100;
           4'd7: w[4:0] = 5'b10001;
           4'd8: w[4:0] = 5'b10010;
           default: w[4:0] = 5'b10100;
         endcase
      3: w = {hi ? 2'b10 : 2'b01, 5'b00001 << pos};
      4: case (d)
           4'd0: w[3:0] = 4'b0000;
           4'd1: w[3:0] = 4'b0011;
           4'd2: w[3:0] = 4'b0010;
           4'd3: w[3:0] = 4'b0101;
           4'd4: w[3:0] = 4'b0100;
           4'd5: w[3:0] = 4'b1001;
           4'd6: w[3:0] = 4'b1000;
           4'd7: w[3:0] = 4'b1011;
           4'd8: w[3:0] = 4'b1010;
           default: w[3:0] = 4'b1101;
         endcase
      default: w[3:0] = d + DIG_W'(3);
    endcase
    return w;
  endfunction
endpackage

// File: rtl/dcc_digit_core.sv
module dcc_digit_core #(
  parameter int unsigned NUM_DIGITS = dcc_pkg::NUM_DIGITS,
  localparam int unsigned DIG_W = $clog2(NUM_DIGITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             dir_i,
  output logic [DIG_W-1:0] digit_o,
  output logic             tc_o
);
  localparam logic [DIG_W-1:0] LAST = DIG_W'(NUM_DIGITS - 1);

  logic [DIG_W-1:0] digit_q, digit_d;
  logic             at_top, at_bot;

  assign at_top = (digit_q == LAST);
  assign at_bot = (digit_q == '0);

  always_comb begin
    digit_d = digit_q;
    if (en_i) begin
      if (dir_i) digit_d = at_top ? '0 : digit_q + DIG_W'(1);
      else       digit_d = at_bot ? LAST : digit_q - DIG_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) digit_q <= '0;
    else         digit_q <= digit_d;
  end

  assign digit_o = digit_q;
  assign tc_o    = en_i & (dir_i ? at_top : at_bot);
endmodule

// File: rtl/dcc_sel_reg.sv
module dcc_sel_reg #(
  parameter int unsigned SEL_W     = dcc_pkg::SEL_W,
  parameter int unsigned NUM_CODES = dcc_pkg::NUM_CODES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] sel_o
);
  logic [SEL_W-1:0] sel_q;

  // illegal selects fold onto excess-3
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         sel_q <= SEL_W'(dcc_pkg::CODE_XS3);
    else if (32'(sel_i) < NUM_CODES)     sel_q <= sel_i;
    else                                 sel_q <= SEL_W'(dcc_pkg::CODE_XS3);
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/dcc_encoder.sv
module dcc_encoder #(
  parameter int unsigned DIG_W     = dcc_pkg::DIG_W,
  parameter int unsigned CODE_W    = dcc_pkg::CODE_W,
  parameter int unsigned SEL_W     = dcc_pkg::SEL_W,
  parameter int unsigned NUM_CODES = dcc_pkg::NUM_CODES
) (
  input  logic [DIG_W-1:0]  digit_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned NUM_SLOTS = 2 ** SEL_W;

  logic [CODE_W-1:0] words [NUM_SLOTS];

  for (genvar c = 0; c < NUM_SLOTS; c++) begin : g_word
    localparam int unsigned CODE_ID = (c < NUM_CODES) ? c : 0;
    assign words[c] = dcc_pkg::encode(digit_i, CODE_ID);
  end

  assign code_o = words[sel_i];
endmodule

// File: rtl/dec_code_counter.sv
module dec_code_counter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       dir_i,
  input  logic [2:0] code_sel_i,
  output logic [6:0] code_o,
  output logic       tc_o
);
  import dcc_pkg::*;

  logic [DIG_W-1:0] digit_q;
  logic [SEL_W-1:0] sel_q;

  dcc_digit_core #(.NUM_DIGITS(NUM_DIGITS)) i_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .dir_i   (dir_i),
    .digit_o (digit_q),
    .tc_o    (tc_o)
  );

  dcc_sel_reg #(.SEL_W(SEL_W), .NUM_CODES(NUM_CODES)) i_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (code_sel_i),
    .sel_o  (sel_q)
  );

  dcc_encoder #(
    .DIG_W(DIG_W), .CODE_W(CODE_W), .SEL_W(SEL_W), .NUM_CODES(NUM_CODES)
  ) i_enc (
    .digit_i (digit_q),
    .sel_i   (sel_q),
    .code_o  (code_o)
  );
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
  parameter int unsigned DIG_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             dir_i,
  input logic             tc_o,
  input logic [6:0]       code_o,
  input logic [DIG_W-1:0] digit_q,
  input logic [2:0]       sel_q
);
  p_up_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && dir_i && digit_q != DIG_W'(9) |=> digit_q == DIG_W'($past(digit_q) + DIG_W'(1)));

  p_up_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && dir_i && digit_q == DIG_W'(9) |=> digit_q == '0);

  p_down_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !dir_i && digit_q == '0 |=> digit_q == DIG_W'(9));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(digit_q));

  p_tc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> en_i && (digit_q == DIG_W'(9) || digit_q == '0));

  p_pad_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q == 3'd0 || sel_q == 3'd1 || sel_q == 3'd4) |-> code_o[6:4] == 3'b000);

  p_two_hot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q == 3'd2 |-> $countones(code_o) == 2);

  p_biq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q == 3'd3 |-> $countones(code_o[6:5]) == 1 && $countones(code_o[4:0]) == 1);
endmodule

bind dec_code_counter dcc_checker #(.DIG_W(dcc_pkg::DIG_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .dir_i   (dir_i),
  .tc_o    (tc_o),
  .code_o  (code_o),
  .digit_q (digit_q),
  .sel_q   (sel_q)
);

// File: tb/test_dec_code_counter.sv
module test_dec_code_counter;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic       dir_i = 1'b1;
  logic [2:0] code_sel_i = 3'd0;
  logic [6:0] code_o;
  logic       tc_o;

  typedef struct {
    logic [6:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    failures = 0;
  int    dig_m = 0;
  int    sel_m = 0;

  dec_code_counter i_dec_code_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .dir_i(dir_i),
    .code_sel_i(code_sel_i), .code_o(code_o), .tc_o(tc_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  function automatic logic [6:0] model_code(int d, int c);
    logic [6:0] two5 [10] = '{7'b11000, 7'b00011, 7'b00101, 7'b00110, 7'b01001,
                              7'b01010, 7'b01100, 7'b10001, 7'b10010, 7'b10100};
    logic [6:0] w642 [10] = '{7'h0, 7'h3, 7'h2, 7'h5, 7'h4, 7'h9, 7'h8, 7'hB, 7'hA, 7'hD};
    case (c)
      1: return (d < 5) ? 7'(d) : 7'(d + 6);
      2: return two5[d];
      3: return {(d < 5) ? 2'b01 : 2'b10, 5'(1 << (d % 5))};
      4: return w642[d];
      default: return 7'(d + 3);
    endcase
  endfunction

  task automatic check(string req, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // driver: one clock step, pushes the expected word after the edge
  task automatic step(logic en, logic dir, logic [2:0] sel, string req);
    logic tc_exp;
    @(negedge clk_i);
    #1;
    en_i = en; dir_i = dir; code_sel_i = sel;
    #1;
    tc_exp = en && ((dir && dig_m == 9) || (!dir && dig_m == 0));
    check("R9", {6'b0, tc_o}, {6'b0, tc_exp});
    @(posedge clk_i);
    if (en) begin
      if (dir) dig_m = (dig_m == 9) ? 0 : dig_m + 1;
      else     dig_m = (dig_m == 0) ? 9 : dig_m - 1;
    end
    sel_m = (sel < 5) ? int'(sel) : 0;
    #1;
    q.push_back('{model_code(dig_m, sel_m), req});
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    #1;
    en_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    dig_m = 0; sel_m = 0;
    check("R11", code_o, 7'b0000011);
    check("R11", {6'b0, tc_o}, 7'b0);
    @(negedge clk_i);
    #1;
    rst_ni = 1'b1;
  endtask

  // monitor
  initial begin
    item_t it;
    forever begin
      @(negedge clk_i);
      if (q.size() > 0) begin
        it = q.pop_front();
        check(it.req, code_o, it.exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2;
    check("R11", code_o, 7'b0000011); // during reset
    @(negedge clk_i);
    #1;
    rst_ni = 1'b1;
    for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 3'd0, "R1/R6");  // excess-3 up, wrap
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 3'd1, "R2");
    for (int i = 0; i < 11; i++) step(1'b1, 1'b0, 3'd2, "R3/R7"); // down, wrap 0->9
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 3'd3, "R4");
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 3'd4, "R5");
    for (int i = 0; i < 4; i++)  step(1'b0, 1'b1, 3'd4, "R8");    // hold
    step(1'b0, 1'b0, 3'd2, "R10");                                 // re-encode, same digit
    step(1'b0, 1'b1, 3'd3, "R10");
    step(1'b0, 1'b1, 3'd1, "R10");
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 3'(5 + (i % 3)), "R1"); // illegal selects
    step(1'b1, 1'b1, 3'd3, "R6");
    step(1'b1, 1'b1, 3'd3, "R6");
    do_reset();
    step(1'b0, 1'b1, 3'd2, "R11");
    step(1'b1, 1'b0, 3'd2, "R7");
    @(negedge clk_i);
    @(negedge clk_i);
    #3;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule